// File: doc/BRIEF.md
# USB IN Endpoint Double-Buffer Controller

This block is the transmit half of one USB device endpoint. A CPU loads payload bytes through a byte write port into one of two packet slots. It marks a slot as ready either by setting the packet-ready bit in an 8-bit control/status register, or by letting hardware mark it once the programmed maximum packet size has been written. Up to two ready packets wait in order. The older one is always the packet offered to the bus.

On the serial side, a packet engine signals each IN token. One cycle later the block states how the token should be answered: with data and its length, with NAK, with STALL, or with a zero-length packet when an isochronous endpoint has nothing queued. The engine pulls the bytes of the current packet one at a time and reports when the packet has gone out. The CPU can flush the queue, stall the endpoint, select isochronous or rate-feedback operation, and watch an underrun flag and a not-empty flag.

Top module: `usb_in_ep_buf`

## Requirements
- R1: After reset the status register reads 0x00, the maximum-size register reads DEPTH (64) and no token response is pending.
- R2: Status register bit positions: 0 packet-ready, 1 underrun, 2 stall, 3 isochronous, 4 rate-feedback select, 5 not-empty, 6 flush, 7 auto-ready. Bits 2, 3, 4 and 7 read back what was last written, and bit 4 also drives `rate_fb`. Bit 6 always reads 0. Bit 5 ignores writes.
- R3: Each accepted byte write appends to the slot being filled. A byte write is ignored when two packets are ready, when the slot already holds DEPTH bytes, or when a status write happens in the same cycle.
- R4: Writing 1 to bit 0 (without bit 6) turns the filling slot, at its current byte count, into a ready packet if fewer than two are ready. Writing 0 to bit 0 never clears it.
- R5: With bit 7 set, the byte write that brings the slot's count equal to the maximum size makes the packet ready at that same clock edge.
- R6: Bit 0 reads 1 while at least one packet is ready. Bit 5 reads 1 while a ready packet or any partially loaded byte is held.
- R7: Writing 1 to bit 6 with one packet ready empties the whole buffer, including partially loaded bytes.
- R8: Writing 1 to bit 6 with two packets ready drops only the older packet. The newer one becomes current with its own length and bytes.
- R9: A pulse on `tok_in` gives, one cycle later, `resp_valid`=1 and a `resp_code` chosen in this priority order: 2 (STALL) when bit 2 is set; 0 (DATA, `resp_len` = length of the older packet) when a packet is ready; 3 (zero-length) when bit 3 is set; 1 (NAK) otherwise.
- R10: `tx_data` shows the current packet's bytes in write order, advancing on each `tx_rd`. A `tx_done` pulse retires the current packet. Bit 0 stays 1 when a second packet was waiting, and that packet becomes current.
- R11: A zero-length response also sets the underrun flag (bit 1). Only a status write with bit 1 = 0 clears it; writing 1 has no effect. A set in the same cycle as a clear wins.
- R12: The maximum-size register reads back its written value, except that values above DEPTH are stored as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register read value |
| mps_we | input | 1 | Maximum packet size write strobe |
| mps_wdata | input | 7 | Maximum packet size write data |
| mps_rdata | output | 7 | Maximum packet size in force |
| byte_we | input | 1 | Payload byte write strobe |
| byte_wdata | input | 8 | Payload byte |
| tok_in | input | 1 | IN token arrived (one-cycle pulse) |
| resp_valid | output | 1 | Token response valid |
| resp_code | output | 2 | 0 DATA, 1 NAK, 2 STALL, 3 zero-length |
| resp_len | output | 7 | Byte count of the DATA response |
| tx_rd | input | 1 | Engine takes the byte on tx_data |
| tx_data | output | 8 | Current byte of the current packet |
| tx_done | input | 1 | Current packet was sent |
| rate_fb | output | 1 | Rate-feedback interrupt mode select |

## Verification
The status, length and byte outputs are combinational views of registers, so a write applied before a clock edge can be seen in the read value just after that edge. The bench drives every stimulus one half-cycle ahead of the edge and samples at the following falling edge. A token's response register loads on the edge that captures `tok_in`, and the underrun flag sets on that same edge, so both are checked at the falling edge one cycle after the token is driven. Each `tx_rd` advances `tx_data` by one byte per edge, and the bench compares each byte before asserting the read that moves past it.

// File: rtl/usb_in_ep_pkg.sv
// Package: shared bit positions, response codes and configuration struct
// for the IN endpoint double buffer. Bit positions are software-visible.
package usb_in_ep_pkg;

    localparam int B_RDY    = 0;
    localparam int B_URUN   = 1;
    localparam int B_STALL  = 2;
    localparam int B_ISO    = 3;
    localparam int B_RFB    = 4;
    localparam int B_NEMPTY = 5;
    localparam int B_FLUSH  = 6;
    localparam int B_AUTO   = 7;

    typedef enum logic [1:0] {
        RESP_DATA  = 2'd0,
        RESP_NAK   = 2'd1,
        RESP_STALL = 2'd2,
        RESP_ZLP   = 2'd3
    } resp_e;

    typedef struct packed {
        logic stall;
        logic iso;
        logic rfb;
        logic auto_set;
    } ep_cfg_t;

endpackage

// File: rtl/usb_in_ep_csr.sv
// Module: usb_in_ep_csr
// Holds the CPU-visible control bits, the sticky underrun flag and the
// maximum packet size register. Decodes status writes into one-cycle
// commit and flush commands. Assumes the read value is sampled by the
// CPU combinationally from registered state.
module usb_in_ep_csr
    import usb_in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int MPS_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [7:0]       csr_wdata,
    input  logic             mps_we,
    input  logic [MPS_W-1:0] mps_wdata,
    input  logic             urun_set,
    input  logic             pkt_rdy,
    input  logic             not_empty,
    output ep_cfg_t          cfg,
    output logic             cmd_commit,
    output logic             cmd_flush,
    output logic [7:0]       csr_rdata,
    output logic [MPS_W-1:0] mps_q
);

    localparam logic [MPS_W-1:0] MPS_MAX = MPS_W'(DEPTH);

    logic urun_q;

    // Command decode: flush takes precedence over a commit in the same write.
    always_comb begin
        cmd_flush  = csr_we && csr_wdata[B_FLUSH];
        cmd_commit = csr_we && csr_wdata[B_RDY] && !csr_wdata[B_FLUSH];
    end

    // Plain read/write configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (csr_we) begin
            cfg.stall    <= csr_wdata[B_STALL];
            cfg.iso      <= csr_wdata[B_ISO];
            cfg.rfb      <= csr_wdata[B_RFB];
            cfg.auto_set <= csr_wdata[B_AUTO];
        end
    end

    // Underrun flag: hardware set wins, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urun_q <= 1'b0;
        end else if (urun_set) begin
            urun_q <= 1'b1;
        end else if (csr_we && !csr_wdata[B_URUN]) begin
            urun_q <= 1'b0;
        end
    end

    // Maximum packet size with clamp to the slot depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mps_q <= MPS_MAX;
        end else if (mps_we) begin
            mps_q <= (mps_wdata > MPS_MAX) ? MPS_MAX : mps_wdata;
        end
    end

    // Read value assembly; flush reads 0.
    always_comb begin
        csr_rdata           = '0;
        csr_rdata[B_RDY]    = pkt_rdy;
        csr_rdata[B_URUN]   = urun_q;
        csr_rdata[B_STALL]  = cfg.stall;
        csr_rdata[B_ISO]    = cfg.iso;
        csr_rdata[B_RFB]    = cfg.rfb;
        csr_rdata[B_NEMPTY] = not_empty;
        csr_rdata[B_AUTO]   = cfg.auto_set;
    end

    assert_urun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_q && !(csr_we && !csr_wdata[B_URUN])) |=> urun_q);

    assert_urun_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        urun_set |=> urun_q);

    assert_mps_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mps_q <= MPS_MAX);

endmodule

// File: rtl/usb_in_ep_fifo.sv
// Module: usb_in_ep_fifo
// Two packet slots used as a ring: one slot is filled by the CPU while
// up to two ready packets wait, oldest first. Handles byte writes,
// manual and automatic commit, flush of the older packet and retiring
// of sent packets. Assumes DEPTH is a power of two and that the
// commit and flush inputs are never both high.
module usb_in_ep_fifo #(
    parameter int DEPTH = 64,
    parameter int MPS_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_busy,
    input  logic             byte_we,
    input  logic [7:0]       byte_wdata,
    input  logic             commit,
    input  logic             flush,
    input  logic             auto_set,
    input  logic [MPS_W-1:0] mps,
    input  logic             tx_rd,
    input  logic             tx_done,
    output logic [1:0]       pkt_cnt,
    output logic [MPS_W-1:0] fill_cnt,
    output logic [MPS_W-1:0] head_len,
    output logic [7:0]       tx_data
);

    localparam int                 PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int                 NSLOT   = 2;
    localparam logic [MPS_W-1:0]   CAP     = MPS_W'(DEPTH);

    logic                    wr_slot;
    logic                    rd_slot;
    logic [MPS_W-1:0]        rd_ptr;
    logic [MPS_W-1:0]        fill_next;
    logic                    byte_ok;
    logic                    auto_push;
    logic                    man_push;
    logic                    push;
    logic [MPS_W-1:0]        push_len;
    logic                    sent_pop;
    logic                    flush_pop;
    logic                    pop;
    logic                    clear_fill;
    logic [NSLOT-1:0][7:0]       slot_rd;
    logic [NSLOT-1:0][MPS_W-1:0] slot_len;

    // Queue control: which events happen this cycle.
    always_comb begin
        fill_next  = fill_cnt + 1'b1;
        byte_ok    = byte_we && !csr_busy && (pkt_cnt != 2'd2) && (fill_cnt < CAP);
        auto_push  = byte_ok && auto_set && (fill_next == mps);
        man_push   = commit && (pkt_cnt != 2'd2);
        push       = auto_push || man_push;
        push_len   = auto_push ? fill_next : fill_cnt;
        sent_pop   = tx_done && (pkt_cnt != 2'd0);
        flush_pop  = flush && !tx_done && (pkt_cnt != 2'd0);
        pop        = sent_pop || flush_pop;
        clear_fill = flush && !tx_done;
    end

    // Per-slot storage and recorded length.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [7:0]       mem [DEPTH];
        logic [MPS_W-1:0] len_r;

        // Payload store for this slot.
        always_ff @(posedge clk) begin
            if (byte_ok && (wr_slot == 1'(s))) begin
                mem[fill_cnt[PTR_W-1:0]] <= byte_wdata;
            end
        end

        // Length captured when this slot becomes ready.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_r <= '0;
            end else if (push && (wr_slot == 1'(s))) begin
                len_r <= push_len;
            end
        end

        assign slot_rd[s]  = mem[rd_ptr[PTR_W-1:0]];
        assign slot_len[s] = len_r;
    end

    // Ready packet count and slot pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt <= '0;
            wr_slot <= 1'b0;
            rd_slot <= 1'b0;
        end else begin
            pkt_cnt <= pkt_cnt + {1'b0, push} - {1'b0, pop};
            if (push) wr_slot <= ~wr_slot;
            if (pop)  rd_slot <= ~rd_slot;
        end
    end

    // Byte count of the slot being filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (clear_fill || push) begin
            fill_cnt <= '0;
        end else if (byte_ok) begin
            fill_cnt <= fill_next;
        end
    end

    // Read pointer into the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= '0;
        end else if (tx_rd && (pkt_cnt != 2'd0) && (rd_ptr < head_len)) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign head_len = slot_len[rd_slot];
    assign tx_data  = slot_rd[rd_slot];

    assert_no_fill_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt == 2'd2) |-> (fill_cnt == '0));

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CAP);

    assert_flush_keeps_newer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !tx_done && pkt_cnt == 2'd2) |=> (pkt_cnt == 2'd1));

    assert_flush_single_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !tx_done && pkt_cnt == 2'd1) |=> (pkt_cnt == 2'd0 && fill_cnt == '0));

    assert_auto_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_set && byte_ok && !tx_done && (fill_next == mps))
        |=> (pkt_cnt == $past(pkt_cnt) + 2'd1) && (fill_cnt == '0));

    assert_read_in_packet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt != 2'd0) |-> (rd_ptr <= head_len));

endmodule

// File: rtl/usb_in_ep_resp.sv
// Module: usb_in_ep_resp
// Registers the answer to each IN token: stall, data, isochronous
// zero-length or NAK, in that priority. Raises a one-cycle underrun set
// when a zero-length answer is given. Assumes tok_in is a single-cycle pulse.
module usb_in_ep_resp
    import usb_in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int MPS_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_in,
    input  ep_cfg_t          cfg,
    input  logic             has_pkt,
    input  logic [MPS_W-1:0] head_len,
    output logic             urun_set,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic [MPS_W-1:0] resp_len
);

    resp_e            code_d;
    logic [MPS_W-1:0] len_d;

    // Priority selection of the token answer.
    always_comb begin
        len_d = '0;
        if (cfg.stall) begin
            code_d = RESP_STALL;
        end else if (has_pkt) begin
            code_d = RESP_DATA;
            len_d  = head_len;
        end else if (cfg.iso) begin
            code_d = RESP_ZLP;
        end else begin
            code_d = RESP_NAK;
        end
        urun_set = tok_in && (code_d == RESP_ZLP);
    end

    // Response register, loaded once per token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RESP_DATA;
            resp_len   <= '0;
        end else begin
            resp_valid <= tok_in;
            if (tok_in) begin
                resp_code <= code_d;
                resp_len  <= len_d;
            end
        end
    end

    assert_stall_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && cfg.stall) |=> (resp_valid && resp_code == RESP_STALL));

    assert_data_when_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && !cfg.stall && has_pkt) |=> (resp_code == RESP_DATA && resp_len == $past(head_len)));

    assert_zlp_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code != RESP_DATA) |-> (resp_len == '0));

endmodule

// File: rtl/usb_in_ep_buf.sv
// Module: usb_in_ep_buf
// Top of the IN endpoint double buffer: connects the register block,
// the two-slot packet store and the token responder. Assumes a single
// clock domain shared by the CPU port and the packet engine.
module usb_in_ep_buf
    import usb_in_ep_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int MPS_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [7:0]       csr_wdata,
    output logic [7:0]       csr_rdata,
    input  logic             mps_we,
    input  logic [MPS_W-1:0] mps_wdata,
    output logic [MPS_W-1:0] mps_rdata,
    input  logic             byte_we,
    input  logic [7:0]       byte_wdata,
    input  logic             tok_in,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic [MPS_W-1:0] resp_len,
    input  logic             tx_rd,
    output logic [7:0]       tx_data,
    input  logic             tx_done,
    output logic             rate_fb
);

    ep_cfg_t          cfg;
    logic             cmd_commit;
    logic             cmd_flush;
    logic             urun_set;
    logic [1:0]       pkt_cnt;
    logic [MPS_W-1:0] fill_cnt;
    logic [MPS_W-1:0] head_len;
    logic             has_pkt;
    logic             not_empty;

    // Derived queue status for the register view and responder.
    always_comb begin
        has_pkt   = (pkt_cnt != 2'd0);
        not_empty = has_pkt || (fill_cnt != '0);
        rate_fb   = cfg.rfb;
    end

    usb_in_ep_csr #(.DEPTH(DEPTH), .MPS_W(MPS_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_we     (csr_we),
        .csr_wdata  (csr_wdata),
        .mps_we     (mps_we),
        .mps_wdata  (mps_wdata),
        .urun_set   (urun_set),
        .pkt_rdy    (has_pkt),
        .not_empty  (not_empty),
        .cfg        (cfg),
        .cmd_commit (cmd_commit),
        .cmd_flush  (cmd_flush),
        .csr_rdata  (csr_rdata),
        .mps_q      (mps_rdata)
    );

    usb_in_ep_fifo #(.DEPTH(DEPTH), .MPS_W(MPS_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_busy   (csr_we),
        .byte_we    (byte_we),
        .byte_wdata (byte_wdata),
        .commit     (cmd_commit),
        .flush      (cmd_flush),
        .auto_set   (cfg.auto_set),
        .mps        (mps_rdata),
        .tx_rd      (tx_rd),
        .tx_done    (tx_done),
        .pkt_cnt    (pkt_cnt),
        .fill_cnt   (fill_cnt),
        .head_len   (head_len),
        .tx_data    (tx_data)
    );

    usb_in_ep_resp #(.DEPTH(DEPTH), .MPS_W(MPS_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_in     (tok_in),
        .cfg        (cfg),
        .has_pkt    (has_pkt),
        .head_len   (head_len),
        .urun_set   (urun_set),
        .resp_valid (resp_valid),
        .resp_code  (resp_code),
        .resp_len   (resp_len)
    );

    assert_ready_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[B_RDY] |-> csr_rdata[B_NEMPTY]);

    assert_flush_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csr_we) |-> !csr_rdata[B_FLUSH]);

endmodule

// File: tb/usb_in_ep_buf_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module usb_in_ep_buf_tb_top;

    localparam int DEPTH = 64;
    localparam int MPS_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             csr_we = 1'b0;
    logic [7:0]       csr_wdata = '0;
    logic [7:0]       csr_rdata;
    logic             mps_we = 1'b0;
    logic [MPS_W-1:0] mps_wdata = '0;
    logic [MPS_W-1:0] mps_rdata;
    logic             byte_we = 1'b0;
    logic [7:0]       byte_wdata = '0;
    logic             tok_in = 1'b0;
    logic             resp_valid;
    logic [1:0]       resp_code;
    logic [MPS_W-1:0] resp_len;
    logic             tx_rd = 1'b0;
    logic [7:0]       tx_data;
    logic             tx_done = 1'b0;
    logic             rate_fb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    usb_in_ep_buf #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .mps_we(mps_we), .mps_wdata(mps_wdata), .mps_rdata(mps_rdata),
        .byte_we(byte_we), .byte_wdata(byte_wdata),
        .tok_in(tok_in), .resp_valid(resp_valid), .resp_code(resp_code), .resp_len(resp_len),
        .tx_rd(tx_rd), .tx_data(tx_data), .tx_done(tx_done), .rate_fb(rate_fb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic csr_wr(input logic [7:0] v);
        csr_we = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic mps_wr(input int v);
        mps_we = 1'b1; mps_wdata = MPS_W'(v);
        @(negedge clk);
        mps_we = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        byte_we = 1'b1; byte_wdata = b;
        @(negedge clk);
        byte_we = 1'b0;
    endtask

    task automatic token(input string req, input int code, input int len);
        tok_in = 1'b1;
        @(negedge clk);
        tok_in = 1'b0;
        check({req, " resp_valid"}, int'(resp_valid), 1);
        check({req, " resp_code"}, int'(resp_code), code);
        check({req, " resp_len"}, int'(resp_len), len);
    endtask

    task automatic pull(input string req, input int n, input int base);
        for (int i = 0; i < n; i++) begin
            check(req, int'(tx_data), base + i);
            tx_rd = 1'b1;
            @(negedge clk);
        end
        tx_rd = 1'b0;
    endtask

    task automatic sent();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    // R1: reset values.
    task automatic t_reset();
        do_reset();
        check("R1 csr", int'(csr_rdata), 8'h00);
        check("R1 mps", int'(mps_rdata), DEPTH);
        check("R1 resp_valid", int'(resp_valid), 0);
    endtask

    // R3, R4, R6, R9, R10: manual ready, one packet out.
    task automatic t_manual();
        do_reset();
        for (int i = 0; i < 5; i++) put_byte(8'(8'h10 + i));
        check("R6 partial not-empty", int'(csr_rdata), 8'h20);
        csr_wr(8'h01);
        check("R4 commit", int'(csr_rdata), 8'h21);
        csr_wr(8'h00);
        check("R4 write 0 keeps ready", int'(csr_rdata), 8'h21);
        token("R9 data", 0, 5);
        pull("R10 bytes", 5, 8'h10);
        sent();
        check("R10 retire last", int'(csr_rdata), 8'h00);
    endtask

    // R3, R10: two packets, extra byte ignored, second becomes current.
    task automatic t_two();
        do_reset();
        for (int i = 0; i < 3; i++) put_byte(8'(8'hA0 + i));
        csr_wr(8'h01);
        for (int i = 0; i < 2; i++) put_byte(8'(8'hB0 + i));
        csr_wr(8'h01);
        check("R6 two ready", int'(csr_rdata), 8'h21);
        put_byte(8'hEE);
        token("R9 older first", 0, 3);
        pull("R10 older bytes", 3, 8'hA0);
        sent();
        check("R10 second keeps ready", int'(csr_rdata), 8'h21);
        token("R3 ignored byte not appended", 0, 2);
        pull("R10 newer bytes", 2, 8'hB0);
        sent();
        check("R10 all retired", int'(csr_rdata), 8'h00);
        // R3: byte in same cycle as status write is dropped.
        byte_we = 1'b1; byte_wdata = 8'h55; csr_we = 1'b1; csr_wdata = 8'h00;
        @(negedge clk);
        byte_we = 1'b0; csr_we = 1'b0;
        check("R3 byte with csr write dropped", int'(csr_rdata), 8'h00);
    endtask

    // R5, R12: auto-ready at maximum size.
    task automatic t_auto();
        do_reset();
        mps_wr(4);
        check("R12 mps readback", int'(mps_rdata), 4);
        csr_wr(8'h80);
        check("R2 auto bit", int'(csr_rdata), 8'h80);
        for (int i = 0; i < 3; i++) put_byte(8'(8'h30 + i));
        check("R5 below size not ready", int'(csr_rdata), 8'hA0);
        put_byte(8'h33);
        check("R5 ready at size", int'(csr_rdata), 8'hA1);
        token("R5 length", 0, 4);
        pull("R5 bytes", 4, 8'h30);
        mps_wr(100);
        check("R12 clamp", int'(mps_rdata), DEPTH);
    endtask

    // R3: slot capacity limit.
    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH + 1; i++) put_byte(8'(i));
        csr_wr(8'h01);
        token("R3 capacity", 0, DEPTH);
        check("R3 first byte", int'(tx_data), 0);
    endtask

    // R7: flush with one packet plus a partial load.
    task automatic t_flush_one();
        do_reset();
        put_byte(8'h01); put_byte(8'h02);
        csr_wr(8'h01);
        put_byte(8'h03);
        check("R7 before flush", int'(csr_rdata), 8'h21);
        csr_wr(8'h40);
        check("R7 empty after flush", int'(csr_rdata), 8'h00);
        token("R9 nak", 1, 0);
    endtask

    // R8: flush with two packets keeps the newer.
    task automatic t_flush_two();
        do_reset();
        put_byte(8'h11); put_byte(8'h12);
        csr_wr(8'h01);
        put_byte(8'h21); put_byte(8'h22); put_byte(8'h23);
        csr_wr(8'h01);
        csr_wr(8'h40);
        check("R8 newer still ready", int'(csr_rdata), 8'h21);
        token("R8 newer length", 0, 3);
        pull("R8 newer bytes", 3, 8'h21);
        sent();
        check("R8 then empty", int'(csr_rdata), 8'h00);
    endtask

    // R2, R9: stall wins over ready data.
    task automatic t_stall();
        do_reset();
        put_byte(8'h77);
        csr_wr(8'h05);
        check("R2 stall bit", int'(csr_rdata), 8'h25);
        token("R9 stall", 2, 0);
    endtask

    // R9, R11: isochronous underrun and flag rules.
    task automatic t_iso();
        do_reset();
        csr_wr(8'h08);
        token("R9 zero-length", 3, 0);
        check("R11 underrun set", int'(csr_rdata), 8'h0A);
        csr_wr(8'h0A);
        check("R11 write 1 keeps", int'(csr_rdata), 8'h0A);
        csr_wr(8'h08);
        check("R11 write 0 clears", int'(csr_rdata), 8'h08);
        tok_in = 1'b1; csr_we = 1'b1; csr_wdata = 8'h08;
        @(negedge clk);
        tok_in = 1'b0; csr_we = 1'b0;
        check("R11 set wins", int'(csr_rdata), 8'h0A);
    endtask

    // R2: bit access rules.
    task automatic t_bits();
        do_reset();
        csr_wr(8'hDC);
        check("R2 rw bits flush reads 0", int'(csr_rdata), 8'h9C);
        check("R2 rate_fb pin", int'(rate_fb), 1);
        csr_wr(8'h20);
        check("R2 not-empty read-only", int'(csr_rdata), 8'h00);
    endtask

    initial begin
        t_reset();
        t_manual();
        t_two();
        t_auto();
        t_full();
        t_flush_one();
        t_flush_two();
        t_stall();
        t_iso();
        t_bits();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule